// File: doc/BRIEF.md
# One-Dimensional Cellular Automaton Row Generator

This block evolves a binary, nearest-neighbour, one-dimensional cellular automaton. It streams each generation, one pixel per clock, into a write-only pixel memory that a separate display path scans out. Generation g becomes screen row g.

The update rule is an 8-bit number read from external switches. Each cell's next state is the rule bit selected by its three-cell neighbourhood. The current row is held in an internal register, so the memory is never read back.

After reset, and whenever the rule number changes, the block first wipes the whole frame to zero. It then draws the seed row and the generations that follow it. After the last row it stops and raises a completion flag.

Top module: `ca1d_engine`

## Requirements
- R1: The next state of cell i is bit {left, centre, right} of the rule number, where left is cell i-1, centre is cell i and right is cell i+1, and the 3-bit value is read with left as its most significant bit.
- R2: Any neighbour position outside the row (to the left of cell 0 or to the right of cell CELLS-1) reads as 0.
- R3: Generation 0 holds a single live cell at index CELLS/2, and every other cell is 0.
- R4: Cell c of generation g is written to address g*CELLS + c with mem_wdata = its state (1 = live), one write per cycle in ascending cell order. Consecutive rows are separated by exactly one cycle with mem_we low.
- R5: After reset or a restart, the block writes 0 to every address 0 .. CELLS*ROWS-1 in ascending order, one per cycle, before it writes generation 0.
- R6: When rule_i differs from the rule in use, the next clock edge restarts the block: done_o drops, and the zero-fill begins at address 0 using the new rule.
- R7: done_o rises on the edge after the write of address CELLS*ROWS-1. It then stays high with mem_we low until reset or a rule change.
- R8: With the rule held, done_o first reads 1 exactly 2*CELLS*ROWS + ROWS-1 clock edges after a restart begins.
- R9: Rule 30 gives, around the seed at index s, live cells s-1, s and s+1 in generation 1, and live cells s-2, s-1 and s+2 in generation 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rule_i | input | 8 | Rule number from the switches |
| mem_we | output | 1 | Pixel memory write enable |
| mem_addr | output | $clog2(CELLS*ROWS) | Pixel address (row*CELLS + column) |
| mem_wdata | output | 1 | Pixel value, 1 = live cell |
| done_o | output | 1 | High once the final row has been written |

## Verification
The write port is a direct decode of the state registers. The address and data for edge k are therefore visible before edge k, and the bench compares them on the falling edge in the same cycle, one address per cycle, through the zero-fill and the seed row. A rule change takes effect one edge later, so the bench samples done_o once before that edge and once after it. The completion flag is due exactly 2*CELLS*ROWS + ROWS-1 edges after a restart, and the bench counts falling edges to sample it one cycle early (expecting 0) and on time (expecting 1). The finished frame is then compared against a row model built in the bench from the rule table.

// File: rtl/ca1d_engine.sv
module ca1d_engine #(
  parameter int CELLS = 32,
  parameter int ROWS  = 24,
  localparam int PIX = CELLS * ROWS,
  localparam int AW  = $clog2(PIX),
  localparam int CW  = $clog2(CELLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    rule_i,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic          mem_wdata,
  output logic          done_o
);

  typedef enum logic [1:0] {S_CLEAR, S_DRAW, S_STEP, S_DONE} st_t;

  localparam logic [CELLS-1:0] SEED = {{(CELLS-1){1'b0}}, 1'b1} << (CELLS / 2);
  localparam logic [AW-1:0]    LAST = AW'(PIX - 1);
  localparam logic [CW-1:0]    LCOL = CW'(CELLS - 1);

  st_t              st;
  logic [AW-1:0]    pix;
  logic [CW-1:0]    col;
  logic [CELLS-1:0] cur, nxt;
  logic [CELLS+1:0] pad;
  logic [7:0]       rule_q;
  logic             restart;

  assign pad     = {1'b0, cur, 1'b0};
  assign restart = (rule_i != rule_q);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign nxt[i] = rule_q[{pad[i], pad[i+1], pad[i+2]}];
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st     <= S_CLEAR;
      pix    <= '0;
      col    <= '0;
      cur    <= SEED;
      rule_q <= rule_i;
    end else begin
      case (st)
        S_CLEAR: begin
          if (pix == LAST) begin
            pix <= '0;
            st  <= S_DRAW;
          end else begin
            pix <= pix + 1'b1;
          end
        end
        S_DRAW: begin
          if (pix != LAST) pix <= pix + 1'b1;
          if (col == LCOL) begin
            col <= '0;
            st  <= (pix == LAST) ? S_DONE : S_STEP;
          end else begin
            col <= col + 1'b1;
          end
        end
        S_STEP: begin
          cur <= nxt;
          st  <= S_DRAW;
        end
        default: st <= S_DONE;
      endcase
    end
  end

  assign mem_we    = (st == S_CLEAR) || (st == S_DRAW);
  assign mem_addr  = pix;
  assign mem_wdata = (st == S_DRAW) && cur[col];
  assign done_o    = (st == S_DONE);

  a_r7_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_we);

  a_r4_addr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr <= LAST));

  a_r4_addr_ascends: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we) && mem_addr != '0) |-> (int'(mem_addr) == int'($past(mem_addr)) + 1));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (mem_we && mem_addr == '0 && !mem_wdata && !done_o));

  a_r7_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ($past(mem_we) && $past(mem_addr) == LAST));

  a_r7_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !restart) |=> done_o);

endmodule

// File: tb/ca1d_engine_tb_top.sv
module ca1d_engine_tb_top;
  localparam int CELLS = 32;
  localparam int ROWS  = 24;
  localparam int PIX   = CELLS * ROWS;
  localparam int AW    = $clog2(PIX);
  localparam int DONE_AT = 2 * PIX + ROWS - 1;
  localparam int S = CELLS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] sw = 8'd30;
  logic mem_we, mem_wdata, done_o;
  logic [AW-1:0] mem_addr;
  logic mem [PIX];
  logic [CELLS-1:0] exp_row [ROWS];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  ca1d_engine #(.CELLS(CELLS), .ROWS(ROWS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rule_i(sw),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done_o(done_o));

  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic build_model(input logic [7:0] r);
    exp_row[0] = '0;
    exp_row[0][S] = 1'b1;
    for (int g = 1; g < ROWS; g++)
      for (int c = 0; c < CELLS; c++) begin
        logic l, m, rt;
        l  = (c == 0) ? 1'b0 : exp_row[g-1][c-1];
        m  = exp_row[g-1][c];
        rt = (c == CELLS - 1) ? 1'b0 : exp_row[g-1][c+1];
        exp_row[g][c] = r[{l, m, rt}];
      end
  endtask

  // Called on the falling edge that follows the start of a zero-fill.
  task automatic follow_run(input logic [7:0] r);
    int errs, bad, first;
    errs = 0;
    for (int i = 0; i < PIX; i++) begin
      if (!(mem_we === 1'b1 && int'(mem_addr) == i && mem_wdata === 1'b0)) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R5 zero-fill sequence errors", errs, 0);
    errs = 0;
    for (int i = 0; i < CELLS; i++) begin
      if (!(mem_we === 1'b1 && int'(mem_addr) == i && mem_wdata === (i == S))) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R3 R4 seed row write errors", errs, 0);
    check(mem_we == 1'b0, "R4 gap cycle after row", mem_we, 0);
    repeat (DONE_AT - 1 - PIX - CELLS) @(negedge clk);
    check(done_o == 1'b0, "R8 done one cycle early", done_o, 0);
    @(negedge clk);
    check(done_o == 1'b1, "R8 done on time", done_o, 1);
    errs = 0;
    repeat (6) begin
      if (done_o !== 1'b1 || mem_we !== 1'b0) errs++;
      @(negedge clk);
    end
    check(errs == 0, "R7 done held with no writes", errs, 0);
    build_model(r);
    bad = 0; first = -1;
    for (int a = 0; a < PIX; a++)
      if (mem[a] !== exp_row[a / CELLS][a % CELLS]) begin
        bad++;
        if (first < 0) first = a;
      end
    check(bad == 0, $sformatf("R1 R2 frame for rule %0d, first bad addr %0d", r, first), bad, 0);
  endtask

  task automatic run_after_reset(input logic [7:0] r);
    rst_n = 1'b0;
    sw = r;
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R7 done low in reset", done_o, 0);
    rst_n = 1'b1;
    follow_run(r);
  endtask

  task automatic change_after_done(input logic [7:0] r);
    sw = r;
    #1;
    check(done_o == 1'b1, "R6 done before edge", done_o, 1);
    @(negedge clk);
    check(done_o == 1'b0, "R6 done dropped after change", done_o, 0);
    follow_run(r);
  endtask

  task automatic change_mid_run(input logic [7:0] a, input logic [7:0] b);
    run_after_reset(a);
    sw = a;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (1000) @(negedge clk);
    sw = b;
    @(negedge clk);
    check(mem_we && mem_addr == 0 && !done_o, "R6 restart mid-draw", mem_addr, 0);
    follow_run(b);
  endtask

  task automatic rule30_shape;
    int r1, r2;
    r1 = {mem[CELLS + S - 1], mem[CELLS + S], mem[CELLS + S + 1]};
    check(r1 == 3'b111, "R9 rule 30 generation 1", r1, 7);
    r2 = {mem[2*CELLS + S - 2], mem[2*CELLS + S - 1], mem[2*CELLS + S],
          mem[2*CELLS + S + 1], mem[2*CELLS + S + 2]};
    check(r2 == 5'b11001, "R9 rule 30 generation 2", r2, 25);
  endtask

  task automatic edge_probe;
    // rule 254: a 1 on either side gives 1; edge padding of 1 would light cell 0 in row 1
    check(mem[CELLS] === 1'b0 && mem[2*CELLS-1] === 1'b0, "R2 row ends stay 0",
          {mem[CELLS], mem[2*CELLS-1]}, 0);
  endtask

  initial begin
    @(negedge clk);
    run_after_reset(8'd30);
    rule30_shape();
    change_after_done(8'd90);
    run_after_reset(8'd254);
    edge_probe();
    run_after_reset(8'd1);
    run_after_reset(8'd110);
    change_mid_run(8'd90, 8'd30);
    rule30_shape();
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule